// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block lets an on-chip requester read and write an external asynchronous static RAM of 128K words of 8 bits. The requester offers one access at a time through a valid/ready handshake. The block accepts an access in a single cycle and then sequences the memory pins over several clock cycles. Those pins are a select pair of opposite polarity, an active-low output enable, an active-low write enable, a 17-bit address and an 8-bit data path. The data path is split into an output value, an output-enable and an input value, so that the tri-state pad can sit outside the block.

Every phase length is a whole number of clocks, fixed at elaboration from the clock period and a speed grade of 55 ns or 70 ns. The clocks for each phase are ceil(time / clock period), with a floor of one. For a 5 ns clock on the 55 ns grade the counts are: access 11, write pulse 8, output-release turnaround 4, write recovery 1. The write strobe produces the write; the select pins are asserted one cycle ahead of it.

The sequencer has seven states:
- `ST_IDLE`: deselected and ready. It moves to `ST_RD_ACC` when a read is accepted and to `ST_WR_SETUP` when a write is accepted.
- `ST_RD_ACC`: selected with the output enable active for the access count. It moves to `ST_RD_TURN` and captures the data at that edge.
- `ST_RD_TURN`: deselected for the turnaround count, then back to `ST_IDLE`.
- `ST_WR_SETUP`: selected for one cycle with no strobe, then on to `ST_WR_PULSE`.
- `ST_WR_PULSE`: the write strobe is low and data is driven for the pulse count, then on to `ST_WR_HOLD`.
- `ST_WR_HOLD`: the strobe is released and data is driven for one more cycle, then on to `ST_WR_REC`.
- `ST_WR_REC`: still selected with nothing driven for the recovery count, then back to `ST_IDLE`.

Top module: `sram_ctl`

## Requirements
- R1: During and right after reset the pins are idle: mem_cs1_n=1, mem_cs2=0, mem_oe_n=1, mem_we_n=1, mem_dq_oe=0. req_ready is 1 and rd_valid is 0.
- R2: An access is accepted only on a clock edge where req_valid and req_ready are both 1. req_ready stays 0 until the sequence returns to idle. Request inputs that change while the block is busy have no effect on the running access.
- R3: A read keeps mem_cs1_n=0, mem_cs2=1, mem_oe_n=0 and mem_we_n=1, with the accepted address, for the access count of cycles (11 in the default build) starting the cycle after acceptance.
- R4: Read data is captured from mem_dq_in on the edge that ends the access phase. rd_valid is 1 for exactly the following cycle, and rd_data then equals the byte last written to that address.
- R5: After each read the pins are deselected with the output enable high for the turnaround count (4). Only after that does req_ready return. The data driver is never on while the memory may still be driving.
- R6: A write selects the memory for one cycle with mem_we_n=1. mem_we_n is then 0 for the pulse count (8), and the select is held throughout.
- R7: mem_dq_oe is 1 from the cycle mem_we_n falls until one cycle after it rises. mem_dq_out carries the accepted byte during that window, which gives at least the data setup time before the strobe rises.
- R8: The select window of a write lasts at least the write cycle time. The setup, pulse, hold and recovery cycles (1+8+1+1) are followed by idle.
- R9: Phase counts equal ceil(time / clock period) with a floor of one, using access 55/70 ns, pulse 40/50 ns, data setup 25/30 ns, release 20/25 ns and cycle 55/70 ns. The pulse count is the larger of the pulse and setup counts.
- R10: mem_addr does not change while the memory is selected.
- R11: mem_dq_oe is never 1 while mem_oe_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Requester offers an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Block can accept an access this cycle |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds fresh read data |
| rd_data | output | 8 | Last captured read byte |
| mem_addr | output | 17 | Memory address pins |
| mem_cs1_n | output | 1 | Select, active low |
| mem_cs2 | output | 1 | Select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq_out | output | 8 | Value for the data pads |
| mem_dq_oe | output | 1 | Data pad driver enable |
| mem_dq_in | input | 8 | Value seen on the data pads |

## Verification
A wrong state or count in the sequencer shows up on the memory pins in the very cycle it goes wrong. The bench compares every pin against a reference model on every clock, so a phase that is one cycle short or long, or a skipped turnaround, is reported within one clock. A behavioural memory in the bench also times each strobe window, data window and output-release interval. Too short an access therefore gives stale rd_data at the rd_valid pulse. A driver that is enabled too early is flagged as contention in the cycle it overlaps the memory's release interval.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_TURN,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_WR_REC
    } sc_state_e;

    typedef enum int {
        TP_ACCESS,
        TP_WPULSE,
        TP_DSETUP,
        TP_RELEASE,
        TP_WCYCLE
    } tparam_e;

    // Timing limits in picoseconds for a supported speed grade.
    function automatic int grade_ps(int grade_ns, tparam_e p);
        int slow;
        slow = (grade_ns == 70) ? 1 : 0;
        case (p)
            TP_ACCESS:  return slow ? 70000 : 55000;
            TP_WPULSE:  return slow ? 50000 : 40000;
            TP_DSETUP:  return slow ? 30000 : 25000;
            TP_RELEASE: return slow ? 25000 : 20000;
            default:    return slow ? 70000 : 55000;
        endcase
    endfunction

    // Whole clocks covering a time, never fewer than one.
    function automatic int clocks(int t_ps, int clk_ps);
        int c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val - CNT_W'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign done = (cnt == '0);

    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0)); // R9

    AST_DONE_AFTER_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val == CNT_W'(1)) |=> done); // R9

endmodule

// File: rtl/sram_req_hold.sv
`timescale 1ns/1ps
module sram_req_hold #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              in_write,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    output logic              hold_write,
    output logic [ADDR_W-1:0] hold_addr,
    output logic [DATA_W-1:0] hold_wdata
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_write <= 1'b0;
            hold_addr  <= '0;
            hold_wdata <= '0;
        end else if (take) begin
            hold_write <= in_write;
            hold_addr  <= in_addr;
            hold_wdata <= in_wdata;
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(hold_addr) && $stable(hold_wdata)); // R2

endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [DATA_W-1:0] pad_in,
    output logic              cap_valid,
    output logic [DATA_W-1:0] cap_data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_valid <= 1'b0;
            cap_data  <= '0;
        end else begin
            cap_valid <= cap;
            if (cap) begin
                cap_data <= pad_in;
            end
        end
    end

    AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> !cap_valid); // R4

endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 8,
    parameter int CLK_PS   = 5000,
    parameter int GRADE_NS = 55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs1_n,
    output logic              mem_cs2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int C_ACC  = clocks(grade_ps(GRADE_NS, TP_ACCESS), CLK_PS);
    localparam int C_WP   = imax(clocks(grade_ps(GRADE_NS, TP_WPULSE), CLK_PS),
                                 clocks(grade_ps(GRADE_NS, TP_DSETUP), CLK_PS));
    localparam int C_HZ   = clocks(grade_ps(GRADE_NS, TP_RELEASE), CLK_PS);
    localparam int C_WC   = clocks(grade_ps(GRADE_NS, TP_WCYCLE), CLK_PS);
    localparam int C_REC  = imax(1, C_WC - C_WP - 2);
    localparam int C_MAX  = imax(imax(C_ACC, C_WP), imax(C_HZ, C_REC));
    localparam int CNT_W  = $clog2(C_MAX + 1);

    initial begin
        AST_GRADE_KNOWN: assert (GRADE_NS == 55 || GRADE_NS == 70)
            else $error("unsupported speed grade %0d", GRADE_NS); // R9
        AST_CLK_POSITIVE: assert (CLK_PS > 0)
            else $error("clock period must be positive"); // R9
    end

    sc_state_e        state, state_nx;
    logic             accept;
    logic             tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;
    logic             hold_write;
    logic             cap;
    logic             cs_act;

    assign accept = req_valid && (state == ST_IDLE);

    sram_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (accept),
        .in_write   (req_write),
        .in_addr    (req_addr),
        .in_wdata   (req_wdata),
        .hold_write (hold_write),
        .hold_addr  (mem_addr),
        .hold_wdata (mem_dq_out)
    );

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap       (cap),
        .pad_in    (mem_dq_in),
        .cap_valid (rd_valid),
        .cap_data  (rd_data)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next state and phase length
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    state_nx = req_write ? ST_WR_SETUP : ST_RD_ACC;
                end
            end
            ST_RD_ACC:   if (tmr_done) state_nx = ST_RD_TURN;
            ST_RD_TURN:  if (tmr_done) state_nx = ST_IDLE;
            ST_WR_SETUP: if (tmr_done) state_nx = ST_WR_PULSE;
            ST_WR_PULSE: if (tmr_done) state_nx = ST_WR_HOLD;
            ST_WR_HOLD:  if (tmr_done) state_nx = ST_WR_REC;
            ST_WR_REC:   if (tmr_done) state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase

        tmr_load = (state_nx != state);
        unique case (state_nx)
            ST_RD_ACC:   tmr_val = CNT_W'(C_ACC);
            ST_RD_TURN:  tmr_val = CNT_W'(C_HZ);
            ST_WR_PULSE: tmr_val = CNT_W'(C_WP);
            ST_WR_REC:   tmr_val = CNT_W'(C_REC);
            default:     tmr_val = CNT_W'(1);
        endcase
    end

    // Pin decode
    always_comb begin
        req_ready = 1'b0;
        cs_act    = 1'b0;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_dq_oe = 1'b0;
        cap       = 1'b0;
        unique case (state)
            ST_IDLE: req_ready = 1'b1;
            ST_RD_ACC: begin
                cs_act   = 1'b1;
                mem_oe_n = 1'b0;
                cap      = tmr_done;
            end
            ST_RD_TURN: ;
            ST_WR_SETUP: cs_act = 1'b1;
            ST_WR_PULSE: begin
                cs_act    = 1'b1;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_WR_HOLD: begin
                cs_act    = 1'b1;
                mem_dq_oe = 1'b1;
            end
            ST_WR_REC: cs_act = 1'b1;
            default: ;
        endcase
        mem_cs1_n = !cs_act;
        mem_cs2   = cs_act;
    end

    AST_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R2

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && $past(cs_act)) |-> $stable(mem_addr)); // R10

    AST_RDV_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(!mem_oe_n)); // R4

    AST_WE_AFTER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(!mem_cs1_n && mem_cs2)); // R6

    AST_DRV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dq_oe); // R7

    AST_WRITE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> hold_write); // R6

    AST_NO_DRIVE_WITH_OE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n); // R11

    AST_TURN_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> !req_ready && !mem_dq_oe); // R5

endmodule

// File: tb/sram_ctl_bench.sv
`timescale 1ns/1ps
module sram_ctl_bench;

    // Reference numbers from the requirements (55 ns grade, 5 ns clock)
    localparam int CLK_PS = 5000;
    localparam int N_ACC  = (55000 + CLK_PS - 1) / CLK_PS;
    localparam int N_WPA  = (40000 + CLK_PS - 1) / CLK_PS;
    localparam int N_DSU  = (25000 + CLK_PS - 1) / CLK_PS;
    localparam int N_WP   = (N_WPA > N_DSU) ? N_WPA : N_DSU;
    localparam int N_HZ   = (20000 + CLK_PS - 1) / CLK_PS;
    localparam int N_WC   = (55000 + CLK_PS - 1) / CLK_PS;
    localparam int N_REC  = (N_WC - N_WP - 2 > 1) ? (N_WC - N_WP - 2) : 1;
    localparam real ACC_NS = 55.0;
    localparam real WP_NS  = 40.0;
    localparam real DW_NS  = 25.0;
    localparam real HZ_NS  = 20.0;
    localparam real WC_NS  = 55.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rd_valid;
    logic [7:0]  rd_data;
    logic [16:0] mem_addr;
    logic        mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hEE;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sram_ctl u_sram_ctl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $realtime);
        end
    endtask

    // ---------------- behavioural memory with timing flags ----------------
    logic [7:0] mem_arr [int];
    logic [7:0] shadow  [int];
    wire sel   = !mem_cs1_n && mem_cs2;
    wire rd_en = sel && !mem_oe_n && mem_we_n;
    wire wr_en = sel && !mem_we_n;
    realtime t_addr = 0, t_rd_on = 0, t_rd_off = -1000, t_wr_on = 0, t_data = 0, t_cs_on = 0;
    bit saw_wr = 1'b0;

    function automatic logic [7:0] arr_rd(input int a);
        return mem_arr.exists(a) ? mem_arr[a] : 8'h00;
    endfunction

    function automatic logic [7:0] sh_rd(input int a);
        return shadow.exists(a) ? shadow[a] : 8'h00;
    endfunction

    always @(rd_en or mem_addr or mem_we_n)
        mem_dq_in = rd_en ? arr_rd(int'(mem_addr)) : 8'hEE;

    always @(mem_addr) t_addr = $realtime;
    always @(mem_dq_out or mem_dq_oe) t_data = $realtime;
    always @(posedge rd_en) t_rd_on = $realtime;
    always @(negedge rd_en) begin
        t_rd_off = $realtime;
        chk("R3", "access window long enough", 32'(($realtime - t_rd_on) >= ACC_NS), 1);
        chk("R10", "address settled before read", 32'(t_addr <= t_rd_on), 1);
    end
    always @(posedge wr_en) t_wr_on = $realtime;
    always @(negedge wr_en) begin
        chk("R6", "write pulse width", 32'(($realtime - t_wr_on) >= WP_NS), 1);
        chk("R7", "data driven at strobe rise", 32'(mem_dq_oe), 1);
        chk("R7", "data setup before strobe rise", 32'(($realtime - t_data) >= DW_NS), 1);
        mem_arr[int'(mem_addr)] = mem_dq_out;
        saw_wr = 1'b1;
    end
    always @(posedge sel) begin
        t_cs_on = $realtime;
        saw_wr  = 1'b0;
    end
    always @(negedge sel) begin
        if (saw_wr && rst_n)
            chk("R8", "write select window", 32'(($realtime - t_cs_on) >= WC_NS), 1);
    end

    // ---------------- cycle reference model ----------------
    int          mode = 0;  // 0 idle, 1 read, 2 write
    int          k = 0;
    logic [16:0] m_addr = '0;
    logic [7:0]  m_wdata = '0;
    logic [7:0]  m_rexp = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            mode = 0;
            k = 0;
            chk("R1", "reset cs1_n", 32'(mem_cs1_n), 1);
            chk("R1", "reset cs2", 32'(mem_cs2), 0);
            chk("R1", "reset oe_n", 32'(mem_oe_n), 1);
            chk("R1", "reset we_n", 32'(mem_we_n), 1);
            chk("R1", "reset dq_oe", 32'(mem_dq_oe), 0);
            chk("R1", "reset ready", 32'(req_ready), 1);
            chk("R1", "reset rd_valid", 32'(rd_valid), 0);
        end else begin
            bit e_cs, e_oe, e_we, e_drv, e_rdv, e_rdy;
            e_rdy = (mode == 0);
            e_cs  = (mode == 1 && k <= N_ACC) || (mode == 2);
            e_oe  = (mode == 1 && k <= N_ACC);
            e_we  = (mode == 2 && k >= 2 && k <= N_WP + 1);
            e_drv = (mode == 2 && k >= 2 && k <= N_WP + 2);
            e_rdv = (mode == 1 && k == N_ACC + 1);
            chk("R2", "req_ready", 32'(req_ready), 32'(e_rdy));
            chk(mode == 2 ? "R6" : "R3", "cs1_n", 32'(mem_cs1_n), 32'(!e_cs));
            chk(mode == 2 ? "R6" : "R5", "cs2", 32'(mem_cs2), 32'(e_cs));
            chk(mode == 1 ? "R3" : "R5", "oe_n", 32'(mem_oe_n), 32'(!e_oe));
            chk("R6", "we_n", 32'(mem_we_n), 32'(!e_we));
            chk("R7", "dq_oe", 32'(mem_dq_oe), 32'(e_drv));
            chk("R4", "rd_valid", 32'(rd_valid), 32'(e_rdv));
            if (e_cs)  chk("R10", "mem_addr", 32'(mem_addr), 32'(m_addr));
            if (e_drv) chk("R7", "dq_out", 32'(mem_dq_out), 32'(m_wdata));
            if (e_rdv) chk("R4", "rd_data", 32'(rd_data), 32'(m_rexp));
            chk("R5", "no bus contention",
                32'(mem_dq_oe && (rd_en || ($realtime - t_rd_off) < HZ_NS)), 0);
            chk("R11", "driver off while oe low", 32'(mem_dq_oe && !mem_oe_n), 0);

            if (mode == 0) begin
                if (req_valid) begin
                    mode    = req_write ? 2 : 1;
                    k       = 1;
                    m_addr  = req_addr;
                    m_wdata = req_wdata;
                    if (req_write) shadow[int'(req_addr)] = req_wdata;
                    m_rexp  = sh_rd(int'(req_addr));
                end
            end else begin
                k++;
                if ((mode == 1 && k > N_ACC + N_HZ) ||
                    (mode == 2 && k > N_WP + 2 + N_REC)) begin
                    mode = 0;
                    k = 0;
                end
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic do_op(input bit wr, input logic [16:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        req_valid = 1'b0;
        req_addr  = ~a;
        req_wdata = ~d;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        idle_cycles(2);
        // R3 R4 R6: single write then read, low address
        do_op(1'b1, 17'h00000, 8'h5A);
        do_op(1'b0, 17'h00000, 8'h00);
        // boundary: highest address
        do_op(1'b1, 17'h1FFFF, 8'hA5);
        do_op(1'b0, 17'h1FFFF, 8'h00);
        // R5: read followed at once by a write, then back-to-back writes and reads
        do_op(1'b0, 17'h00000, 8'h00);
        do_op(1'b1, 17'h00001, 8'hFF);
        do_op(1'b1, 17'h00002, 8'h00);
        do_op(1'b0, 17'h00001, 8'h00);
        do_op(1'b0, 17'h00002, 8'h00);
        do_op(1'b0, 17'h12345, 8'h00);
        idle_cycles(5);
        // R2: request held valid while inputs change every cycle
        @(posedge clk); #1;
        req_valid = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            req_write = $urandom_range(0, 1) == 1;
            req_addr  = (i % 7 == 0) ? 17'h1FFFF : 17'($urandom_range(0, 15));
            req_wdata = 8'($urandom);
            @(posedge clk); #1;
        end
        req_valid = 1'b0;
        idle_cycles(30);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule